// File: doc/BRIEF.md
# Low-Frequency Watchdog with Masked Match

This block is a watchdog built around a free-running up-counter clocked by a slow always-on clock. It compares the counter against a programmable match value. A resolution field removes a chosen number of the counter's most significant bits from that compare. Each time the compared bits become equal, the block raises one match event. Depending on a mode bit and on the power state, the event either becomes a pending, maskable interrupt or a single-cycle request to reset the device. While the CPU sleeps, the interrupt request is also driven onto a wakeup line for an external wakeup controller.

The counter never reloads. To get periodic operation, software advances the match value by the period after each event and then clears the pending flag. The match and configuration registers sit behind a two-key lock. The lock closes at reset and whenever the power controller signals a return from a deep low-power state.

Register map (`bus_waddr` / `bus_raddr`):
- 0: key register (write). Reads return bit 0 = locked.
- 1: match value.
- 2: configuration. Bits [3:0] hold the ignore count, bit 4 is the mode (1 = reset), bit 5 is the interrupt mask.
- 3: status. Bit 0 is the pending flag, cleared by writing 1.
- 4: counter (read only).

Top module: `lf_watchdog`

## Requirements
- R1: After reset the counter is 0. It increments by one on every `lf_clk` edge, wraps from 0xFFFF to 0, and is never cleared or reloaded by a match; it reads at address 4.
- R2: With ignore count N in configuration bits [3:0] (values above 12 act as 12), the compare uses only counter bits [15-N:0] against match bits [15-N:0].
- R3: A match event fires only on the cycle the compared bits enter equality. One event occurs per equality interval, so with N=12 exactly 4 events occur in any 64-cycle window.
- R4: After reset the lock is closed: address 0 reads 1, and writes to addresses 1 and 2 leave them unchanged (both read 0).
- R5: Writing 0xACED and then 0x5EED as consecutive key-register writes opens the lock (address 0 reads 0). Any other value written to the key register closes it at once.
- R6: A one-cycle pulse on `sleep_exit` closes the lock, after which match writes are ignored.
- R7: In interrupt mode (bit 4 = 0) outside hibernate, an event sets status bit 0. Writing 1 to that bit clears it in any lock state. Writing 0 has no effect, and a new event in the same cycle wins over a clear.
- R8: `match_irq` is high exactly while the pending flag and mask bit 5 are both set.
- R9: `wake_req` follows `match_irq` while `pwr_mode` is 1 (sleep) or 2 (deep sleep), and is low otherwise.
- R10: When mode bit 4 is 1 or `pwr_mode` is 3 (hibernate), an event drives `sys_rst_req` high for exactly the one cycle after the equality cycle and does not set the pending flag.
- R11: `bus_rdata` combinationally returns the register selected by `bus_raddr` per the map above. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lf_clk | input | 1 | Low-frequency counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 16 | Read data |
| sleep_exit | input | 1 | Pulse on return from a deep low-power state; closes the lock |
| pwr_mode | input | 2 | 0 run, 1 sleep, 2 deep sleep, 3 hibernate |
| match_irq | output | 1 | Masked pending match interrupt |
| wake_req | output | 1 | Wakeup request while the CPU sleeps |
| sys_rst_req | output | 1 | One-cycle device reset request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and an ignore limit of 12. Ignore counts of 8 and 12 shrink the match period to 256 and 16 cycles, so masked compares, repeated events and software-advanced periodic matches occur many times in a short run. Because the counter is only 16 bits wide, a single idle stretch of about 65,600 cycles covers a full wraparound and a full-width match. A behavioural model built on modulo arithmetic follows every clock.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_e;

  localparam logic [1:0] PW_RUN   = 2'd0;
  localparam logic [1:0] PW_SLEEP = 2'd1;
  localparam logic [1:0] PW_DEEP  = 2'd2;
  localparam logic [1:0] PW_HIB   = 2'd3;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_KEY   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_MATCH = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CFG   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CNT   = 3'd4;

endpackage

// File: rtl/lfw_keylock.sv
module lfw_keylock
  import lfw_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hACED,
  parameter logic [KEY_W-1:0] KEY_SECOND = 16'h5EED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  input  logic             relock,
  output logic             locked
);

  lk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock) begin
      st_d = LK_SHUT;
    end else if (key_we) begin
      if (key_data == KEY_FIRST)
        st_d = LK_HALF;
      else if (key_data == KEY_SECOND && st_q == LK_HALF)
        st_d = LK_OPEN;
      else
        st_d = LK_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign locked = (st_q != LK_OPEN);

  // R5: the lock opens only right after the second key
  a_r5_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(key_we && key_data == KEY_SECOND));

  // R6: a wake-exit pulse always leaves the lock closed
  a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
    relock |=> locked);

endmodule

// File: rtl/lfw_timebase.sv
module lfw_timebase #(
  parameter int CNT_W   = 16,
  parameter int IGN_MAX = 12,
  parameter int IGN_W   = $clog2(IGN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IGN_W-1:0] ign,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IGN_W-1:0] ign_eff;
  logic [CNT_W-1:0] keep;
  logic             eq, eq_q;

  assign ign_eff = (ign > IGN_W'(IGN_MAX)) ? IGN_W'(IGN_MAX) : ign;

  // bit b takes part in the compare when b <= CNT_W-1-N
  for (genvar b = 0; b < CNT_W; b++) begin : g_keep
    localparam int LIM = CNT_W - 1 - b;
    assign keep[b] = (int'(ign_eff) <= LIM);
  end

  assign cnt_d = cnt_q + 1'b1;
  assign eq    = ((cnt_q ^ match_val) & keep) == '0;
  assign hit   = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eq_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      eq_q  <= eq;
    end
  end

  assign count = cnt_q;

  // R1: free-running step, no reload on a match
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R3: no back-to-back events from one equality interval
  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/lfw_route.sv
module lfw_route
  import lfw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       rst_mode,
  input  logic [1:0] pwr,
  input  logic       mask,
  input  logic       clr_we,
  input  logic       clr_bit,
  output logic       pending,
  output logic       irq,
  output logic       wake,
  output logic       rst_req
);

  logic pend_q, pend_d;
  logic rst_q, rst_d;
  logic int_path;

  assign int_path = !rst_mode && (pwr != PW_HIB);

  always_comb begin
    pend_d = pend_q;
    if (hit && int_path)
      pend_d = 1'b1;
    else if (clr_we && clr_bit)
      pend_d = 1'b0;
    rst_d = hit && !int_path;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rst_q  <= rst_d;
    end
  end

  assign pending = pend_q;
  assign irq     = pend_q & mask;
  assign wake    = irq & ((pwr == PW_SLEEP) || (pwr == PW_DEEP));
  assign rst_req = rst_q;

  // R10: reset request lasts a single cycle
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: pending never rises through the reset path
  a_r10_no_pend_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(int_path));

  // R7: a clear without a coinciding event empties the flag
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bit && !hit) |=> !pend_q);

endmodule

// File: rtl/lf_watchdog.sv
module lf_watchdog
  import lfw_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int IGN_MAX = 12,
  parameter logic [CNT_W-1:0] KEY_FIRST  = 16'hACED,
  parameter logic [CNT_W-1:0] KEY_SECOND = 16'h5EED
) (
  input  logic             lf_clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_waddr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [2:0]       bus_raddr,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             sleep_exit,
  input  logic [1:0]       pwr_mode,
  output logic             match_irq,
  output logic             wake_req,
  output logic             sys_rst_req
);

  localparam int IGN_W   = $clog2(IGN_MAX + 1);
  localparam int MODE_B  = IGN_W;
  localparam int MASK_B  = IGN_W + 1;
  localparam int CFG_W   = IGN_W + 2;

  logic             locked;
  logic             key_we, match_we, cfg_we, stat_we;
  logic [CNT_W-1:0] match_q, match_d;
  logic [IGN_W-1:0] ign_q, ign_d;
  logic             mode_q, mode_d, mask_q, mask_d;
  logic [CNT_W-1:0] count;
  logic             hit, pending;

  assign key_we   = bus_we && (bus_waddr == RA_KEY);
  assign match_we = bus_we && (bus_waddr == RA_MATCH) && !locked;
  assign cfg_we   = bus_we && (bus_waddr == RA_CFG) && !locked;
  assign stat_we  = bus_we && (bus_waddr == RA_STAT);

  lfw_keylock #(
    .KEY_W(CNT_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_lock (
    .clk(lf_clk), .rst_n(rst_n), .key_we(key_we), .key_data(bus_wdata),
    .relock(sleep_exit), .locked(locked)
  );

  always_comb begin
    match_d = match_q;
    ign_d   = ign_q;
    mode_d  = mode_q;
    mask_d  = mask_q;
    if (match_we) match_d = bus_wdata;
    if (cfg_we) begin
      ign_d  = bus_wdata[IGN_W-1:0];
      mode_d = bus_wdata[MODE_B];
      mask_d = bus_wdata[MASK_B];
    end
  end

  always_ff @(posedge lf_clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      ign_q   <= '0;
      mode_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      ign_q   <= ign_d;
      mode_q  <= mode_d;
      mask_q  <= mask_d;
    end
  end

  lfw_timebase #(
    .CNT_W(CNT_W), .IGN_MAX(IGN_MAX), .IGN_W(IGN_W)
  ) u_time (
    .clk(lf_clk), .rst_n(rst_n), .ign(ign_q), .match_val(match_q),
    .count(count), .hit(hit)
  );

  lfw_route u_route (
    .clk(lf_clk), .rst_n(rst_n), .hit(hit), .rst_mode(mode_q),
    .pwr(pwr_mode), .mask(mask_q), .clr_we(stat_we), .clr_bit(bus_wdata[0]),
    .pending(pending), .irq(match_irq), .wake(wake_req), .rst_req(sys_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      RA_KEY:   bus_rdata[0] = locked;
      RA_MATCH: bus_rdata = match_q;
      RA_CFG:   bus_rdata[CFG_W-1:0] = {mask_q, mode_q, ign_q};
      RA_STAT:  bus_rdata[0] = pending;
      RA_CNT:   bus_rdata = count;
      default:  bus_rdata = '0;
    endcase
  end

  // R4: a locked block keeps its match value
  a_r4_locked_match: assert property (@(posedge lf_clk) disable iff (!rst_n)
    (locked && bus_we && bus_waddr == RA_MATCH) |=> $stable(match_q));

  // R4: a locked block keeps its configuration
  a_r4_locked_cfg: assert property (@(posedge lf_clk) disable iff (!rst_n)
    (locked && bus_we && bus_waddr == RA_CFG) |=> $stable({mask_q, mode_q, ign_q}));

endmodule

// File: tb/test_lf_watchdog.sv
module test_lf_watchdog;

  localparam int CW = 16;

  logic          lf_clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [2:0]    bus_waddr, bus_raddr;
  logic [CW-1:0] bus_wdata, bus_rdata;
  logic          sleep_exit;
  logic [1:0]    pwr_mode;
  logic          match_irq, wake_req, sys_rst_req;

  always #4 lf_clk = ~lf_clk;

  lf_watchdog #(.CNT_W(CW), .IGN_MAX(12)) i_lf_watchdog (
    .lf_clk(lf_clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .sleep_exit(sleep_exit), .pwr_mode(pwr_mode), .match_irq(match_irq),
    .wake_req(wake_req), .sys_rst_req(sys_rst_req)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_match, m_ign, m_mode, m_mask, m_lk, m_pend, m_eqp, m_rst;
  int eff, per, e_rd, e_irq, e_wake;
  bit eq, ev, ip;

  always @(posedge lf_clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_ign = 0; m_mode = 0; m_mask = 0;
      m_lk = 0; m_pend = 0; m_eqp = 1; m_rst = 0;
    end else begin
      eff = (m_ign > 12) ? 12 : m_ign;
      per = 1 << (16 - eff);
      eq  = (m_cnt % per) == (m_match % per);
      ev  = eq && !m_eqp;
      ip  = (m_mode == 0) && (pwr_mode != 2'd3);
      m_rst = (ev && !ip) ? 1 : 0;
      if (ev && ip) m_pend = 1;
      else if (bus_we && bus_waddr == 3'd3 && bus_wdata[0]) m_pend = 0;
      if (bus_we && m_lk == 2 && bus_waddr == 3'd1) m_match = int'(bus_wdata);
      if (bus_we && m_lk == 2 && bus_waddr == 3'd2) begin
        m_ign = int'(bus_wdata[3:0]); m_mode = int'(bus_wdata[4]); m_mask = int'(bus_wdata[5]);
      end
      if (sleep_exit) m_lk = 0;
      else if (bus_we && bus_waddr == 3'd0) begin
        if (bus_wdata == 16'hACED) m_lk = 1;
        else if (bus_wdata == 16'h5EED && m_lk == 1) m_lk = 2;
        else m_lk = 0;
      end
      m_cnt = (m_cnt + 1) % 65536;
      m_eqp = eq ? 1 : 0;
    end
    #2;
    e_irq  = m_pend & m_mask;
    e_wake = (e_irq != 0 && (pwr_mode == 2'd1 || pwr_mode == 2'd2)) ? 1 : 0;
    case (bus_raddr)
      3'd0: e_rd = (m_lk == 2) ? 0 : 1;
      3'd1: e_rd = m_match;
      3'd2: e_rd = (m_mask << 5) | (m_mode << 4) | m_ign;
      3'd3: e_rd = m_pend;
      3'd4: e_rd = m_cnt;
      default: e_rd = 0;
    endcase
    chk(match_irq == e_irq[0], "R8 match_irq", match_irq, e_irq);
    chk(wake_req == e_wake[0], "R9 wake_req", wake_req, e_wake);
    chk(sys_rst_req == m_rst[0], "R10 sys_rst_req", sys_rst_req, m_rst);
    chk(int'(bus_rdata) == e_rd, "R11 bus_rdata", bus_rdata, e_rd);
  end

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge lf_clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge lf_clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge lf_clk);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic unlock();
    wr(3'd0, 16'hACED);
    wr(3'd0, 16'h5EED);
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge lf_clk);
      seen = match_irq;
    end
  endtask

  task automatic count_rst(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge lf_clk);
      if (sys_rst_req) n++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge lf_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    logic [CW-1:0] v, v2, m;
    bit seen;
    int n;
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0;
    bus_raddr = '0; sleep_exit = 1'b0; pwr_mode = 2'd0;
    repeat (3) @(negedge lf_clk);
    bus_raddr = 3'd0; #1;
    chk(bus_rdata == 16'd1, "R4 locked in reset", bus_rdata, 1);
    bus_raddr = 3'd4; #1;
    chk(bus_rdata == 16'd0, "R1 counter zero in reset", bus_rdata, 0);
    @(negedge lf_clk); rst_n = 1'b1;

    // writes while locked are ignored
    wr(3'd1, 16'h0033); rd(3'd1, v);
    chk(v == 16'd0, "R4 match write ignored", v, 0);
    wr(3'd2, 16'h003C); rd(3'd2, v);
    chk(v == 16'd0, "R4 cfg write ignored", v, 0);

    // lock sequences
    unlock(); rd(3'd0, v);
    chk(v == 16'd0, "R5 unlocked", v, 0);
    wr(3'd0, 16'hACED); wr(3'd0, 16'h1234); rd(3'd0, v);
    chk(v == 16'd1, "R5 bad second key", v, 1);
    unlock(); wr(3'd0, 16'h0000); rd(3'd0, v);
    chk(v == 16'd1, "R5 relock by other value", v, 1);
    unlock();

    // counter free-running
    rd(3'd4, v); repeat (4) @(negedge lf_clk); rd(3'd4, v2);
    chk(v2 == v + 16'd5, "R1 counter step", v2, v + 16'd5);

    // masked compare with ignore 12, pending and W1C
    wr(3'd2, 16'h002C); wr(3'd1, 16'h0005);
    wait_irq(40, seen);
    chk(seen, "R8 irq raised", seen, 1);
    rd(3'd3, v);
    chk(v == 16'd1, "R7 pending set", v, 1);
    wr(3'd3, 16'h0000); rd(3'd3, v);
    chk(v == 16'd1, "R7 write 0 no effect", v, 1);
    wr(3'd3, 16'h0001); rd(3'd3, v);
    chk(v == 16'd0, "R7 write 1 clears", v, 0);

    // periodic operation with software-advanced match, ignore 8
    wr(3'd2, 16'h0028); wr(3'd3, 16'h0001);
    for (int k = 0; k < 3; k++) begin
      rd(3'd4, v);
      m = v + 16'd40 + 16'h3300;
      wr(3'd1, m);
      wr(3'd3, 16'h0001);
      wait_irq(300, seen);
      bus_raddr = 3'd4; #1 v2 = bus_rdata;
      chk(seen, "R2 periodic event", seen, 1);
      chk(v2[7:0] == 8'(m + 16'd1), "R2 masked match position", v2[7:0], 8'(m + 16'd1));
      wr(3'd3, 16'h0001);
    end

    // wakeup in sleep
    wr(3'd2, 16'h002C); wr(3'd3, 16'h0001);
    pwr_mode = 2'd1;
    wait_irq(40, seen); #1;
    chk(wake_req == 1'b1, "R9 wake in sleep", wake_req, 1);
    pwr_mode = 2'd0; #1;
    chk(wake_req == 1'b0, "R9 no wake in run", wake_req, 0);
    wr(3'd3, 16'h0001);

    // reset mode: four single-cycle pulses per 64 cycles
    wr(3'd2, 16'h003C); wr(3'd3, 16'h0001);
    count_rst(64, n);
    chk(n == 4, "R3 one event per interval", n, 4);
    rd(3'd3, v);
    chk(v == 16'd0, "R10 no pending in reset mode", v, 0);

    // hibernate overrides interrupt mode
    wr(3'd2, 16'h002C); wr(3'd3, 16'h0001);
    pwr_mode = 2'd3;
    count_rst(64, n);
    chk(n == 4, "R10 hibernate reset", n, 4);
    rd(3'd3, v);
    chk(v == 16'd0, "R10 no pending in hibernate", v, 0);
    pwr_mode = 2'd0;

    // wake-exit relock
    @(negedge lf_clk); sleep_exit = 1'b1;
    @(negedge lf_clk); sleep_exit = 1'b0;
    rd(3'd0, v);
    chk(v == 16'd1, "R6 relocked", v, 1);
    rd(3'd1, v2); wr(3'd1, 16'hBEEF); rd(3'd1, v);
    chk(v == v2, "R6 match write ignored", v, v2);

    // full-width compare across a wrap
    unlock(); wr(3'd2, 16'h0020); wr(3'd1, 16'h0010); wr(3'd3, 16'h0001);
    wait_irq(66000, seen);
    bus_raddr = 3'd4; #1 v = bus_rdata;
    chk(seen, "R1 wrap reaches match", seen, 1);
    chk(v == 16'h0011, "R2 full-width match", v, 16'h0011);

    repeat (4) @(negedge lf_clk);
    finish_run();
  end

endmodule